// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies a signed M-bit multiplicand by a signed N-bit multiplier over N clock cycles and returns the two's-complement product on an (M+N)-bit output. A single start strobe captures both operands. Each following cycle inspects the lowest multiplier bit together with the bit retired one step earlier. Depending on that pair, it adds the multiplicand to the upper part of a shift register, subtracts it, or leaves the register unchanged. The whole register then moves one place right, with the sign bit copied into the top.

The working register holds a sign-guard bit, an upper accumulator field and the multiplier, plus one extra low bit that starts at zero. The guard bit makes the accumulator field one bit wider than the multiplicand. This lets the most negative multiplicand be negated without overflow. The block keeps the negated multiplicand in a register from the moment of the start strobe, so no step has to negate it again. When `done_o` pulses, the result on `product_o` is valid, and it stays there until the next accepted start.

Top module: `booth_mul`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A start is accepted when `start_i` is 1 and `busy_o` is 0. Both operands are sampled on that edge. `busy_o` is then 1 for exactly N consecutive cycles, beginning in the cycle after acceptance.
- R3: When `start_i` is asserted while `busy_o` is 1, it has no effect: the operation in flight keeps its operands, its length and its result.
- R4: `done_o` is high for exactly one cycle. That cycle directly follows the last cycle in which `busy_o` is 1, and in it `busy_o` is 0.
- R5: While `done_o` is 1, `product_o` equals the signed product of the sampled operands, read as (M+N)-bit two's complement, for every operand pair.
- R6: A multiplicand of -2^(M-1) gives the correct product for every multiplier. This includes the pair of most negative values, whose product is +2^(M+N-2) (with M=N=4: -8 × -8 = 0x40).
- R7: With M=N=4, multiplicand 3 and multiplier -4 give `product_o` = 8'hF4 (-12).
- R8: After `done_o`, `product_o` holds its value until the next accepted start.
- R9: For the whole of an operation, the stored subtract operand is the exact (M+1)-bit two's-complement negation of the stored sign-extended multiplicand. Within each step, the bit pair 01 adds the multiplicand, 10 subtracts it, and 00 or 11 leaves the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start strobe; accepted only while idle |
| mcand_i | input | M | Signed multiplicand |
| mplr_i | input | N | Signed multiplier |
| busy_o | output | 1 | High while the N steps run |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| product_o | output | M+N | Signed product |

## Verification
At M=N=4, the bench runs all 256 operand pairs. This sweep reaches every recoding pattern: runs of ones that stop below the top bit, runs that pass through the sign bit, isolated ones, and all-zero and all-one multipliers. A wrong add/subtract choice or a logical shift in place of an arithmetic one therefore changes some product. The rows with a most-negative multiplicand show whether the guard bit is present, because without it negating -8 overflows. The pair 3 × -4 pins down the worked case exactly. Operations started with a stray start strobe during the busy phase show whether operands are resampled mid-flight. Idle periods after completion show whether the result drifts.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // Action picked by one recoding step.
  typedef enum logic [1:0] {
    OP_KEEP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic [1:0] pair_i,  // {current multiplier bit, previously retired bit}
  output booth_op_e  op_o
);
  always_comb begin
    unique case (pair_i)
      2'b01:   op_o = OP_ADD;   // end of a run of ones
      2'b10:   op_o = OP_SUB;   // start of a run of ones
      default: op_o = OP_KEEP;  // inside a run or between runs
    endcase
  end

  // R9: the decoder never asks for a change when both bits agree
  always_comb begin
    if (pair_i[1] == pair_i[0]) begin
      a_keep_on_equal_r9: assert (op_o == OP_KEEP);
    end
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int unsigned N_STEPS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic load_o,
  output logic step_o
);
  localparam int unsigned CW = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(N_STEPS - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign cnt_en = load_o | busy_q;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    if (load_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R4: completion is a single-cycle pulse
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R4: the pulse follows the last busy cycle
  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  // R3: a strobe during a non-final step does not end or restart the run
  p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
  // R2: the step counter stays inside the N-step window
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST));
endmodule

// File: rtl/booth_dpath.sv
module booth_dpath
  import booth_pkg::*;
#(
  parameter int unsigned M_W = 8,
  parameter int unsigned N_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [M_W-1:0]   mcand_i,
  input  logic [N_W-1:0]   mplr_i,
  output logic [M_W+N_W-1:0] product_o
);
  localparam int unsigned U_W = M_W + 1;          // accumulator field with guard bit
  localparam int unsigned P_W = U_W + N_W + 1;    // plus multiplier and extra low bit

  logic [P_W-1:0] acc_q, acc_d;
  logic [U_W-1:0] add_q, add_d;
  logic [U_W-1:0] sub_q, sub_d;
  logic [U_W-1:0] upper, upper_sum;
  logic [P_W-1:0] summed;
  booth_op_e      op;

  booth_recode u_recode (
    .pair_i (acc_q[1:0]),
    .op_o   (op)
  );

  // Operands prepared once at start: sign-extended and its negation.
  always_comb begin
    add_d = {mcand_i[M_W-1], mcand_i};
    sub_d = ~add_d + 1'b1;
  end

  always_comb begin
    upper = acc_q[P_W-1 -: U_W];
    unique case (op)
      OP_ADD:  upper_sum = upper + add_q;
      OP_SUB:  upper_sum = upper + sub_q;
      default: upper_sum = upper;
    endcase
    summed = {upper_sum, acc_q[N_W:0]};
  end

  always_comb begin
    acc_d = acc_q;
    if (load_i) begin
      acc_d = {{U_W{1'b0}}, mplr_i, 1'b0};
    end else if (step_i) begin
      acc_d = {summed[P_W-1], summed[P_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      add_q <= '0;
      sub_q <= '0;
    end else begin
      if (load_i | step_i) acc_q <= acc_d;
      if (load_i) begin
        add_q <= add_d;
        sub_q <= sub_d;
      end
    end
  end

  assign product_o = acc_q[M_W+N_W:1];

  // R9: stored operands cancel exactly, including the most negative multiplicand
  p_neg_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> ((add_q + sub_q) == '0));
  // R2: a fresh start clears the extra low bit and the accumulator field
  p_load_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (acc_q[0] == 1'b0 && acc_q[P_W-1 -: U_W] == '0));
  // R8: the result is frozen while idle without a new start
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(product_o));
endmodule

// File: rtl/booth_mul.sv
module booth_mul #(
  parameter int unsigned M_W = 8,
  parameter int unsigned N_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [M_W-1:0]     mcand_i,
  input  logic [N_W-1:0]     mplr_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [M_W+N_W-1:0] product_o
);
  logic load, step;

  booth_ctrl #(.N_STEPS(N_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .load_o  (load),
    .step_o  (step)
  );

  booth_dpath #(.M_W(M_W), .N_W(N_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .step_i    (step),
    .mcand_i   (mcand_i),
    .mplr_i    (mplr_i),
    .product_o (product_o)
  );
endmodule

// File: tb/booth_mul_tb.sv
module booth_mul_tb;
  localparam int M = 4;
  localparam int N = 4;
  localparam int W = M + N;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [M-1:0] mcand_i = '0;
  logic [N-1:0] mplr_i = '0;
  logic         busy_o, done_o;
  logic [W-1:0] product_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] last_exp = '0;
  int  busy_cnt = 0;
  bit  prev_done = 1'b0;
  bit  finished = 1'b0;

  booth_mul #(.M_W(M), .N_W(N)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplr_i    (mplr_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Monitor: pops expected results as completions appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        chk(prev_done == 1'b0, "R4 done width", 1, 0);
        chk(busy_o == 1'b0, "R4 busy low at done", busy_o, 0);
        chk(busy_cnt == N, "R2 busy length", busy_cnt, N);
        busy_cnt = 0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected done", product_o, 0);
        end else begin
          automatic logic [W-1:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(product_o == e, t, product_o, e);
          last_exp = e;
        end
      end
      if (busy_o) busy_cnt++;
      prev_done = done_o;
    end
  end

  // Driver: one operation, optional stray strobe while busy
  task automatic run_op(input int a, input int b, input bit noise, input string tag);
    @(negedge clk);
    exp_q.push_back(W'(a * b));
    tag_q.push_back(tag);
    start_i = 1'b1;
    mcand_i = M'(a);
    mplr_i  = N'(b);
    @(negedge clk);
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    if (noise) begin
      mcand_i = M'(a + 5);
      mplr_i  = N'(b - 3);   // strobe held with other operands: R3
      @(negedge clk);
    end
    start_i = 1'b0;
    mcand_i = '0;
    mplr_i  = '0;
    while (!done_o) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 flags in reset", {busy_o, done_o}, 0);
    chk(product_o == '0, "R1 product in reset", product_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0 && product_o == '0, "R1 after release",
        product_o, 0);

    run_op(3, -4, 1'b0, "R7 3 x -4");
    chk(product_o == 8'hF4, "R7 value", product_o, 8'hF4);

    for (int a = -(1 << (M-1)); a < (1 << (M-1)); a++) begin
      for (int b = -(1 << (N-1)); b < (1 << (N-1)); b++) begin
        if (a == -(1 << (M-1)))
          run_op(a, b, 1'b0, "R6 R9 most negative multiplicand");
        else
          run_op(a, b, 1'b0, "R5 product");
      end
    end

    run_op(-8, -8, 1'b0, "R6 both most negative");
    chk(product_o == 8'h40, "R6 +64", product_o, 8'h40);

    run_op(5, -3, 1'b1, "R3 strobe while busy");
    run_op(-7, 6, 1'b1, "R3 strobe while busy");

    repeat (4) @(negedge clk);
    chk(product_o == last_exp, "R8 hold while idle", product_o, last_exp);
    chk(exp_q.size() == 0, "R3 no extra operation", exp_q.size(), 0);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule